// File: doc/BRIEF.md
# Host-to-Processor Byte Mailbox

This block passes single bytes in both directions between an external host bus and an on-chip processor. The host writes a byte into an inbound register, and the processor reads it from there. The processor writes a byte into an outbound register, and the host reads it from there. Two handshake flags tell each side whether a byte is waiting:

- **inbound-full** is raised by a host write and lowered when the processor consumes the byte. It also drives the processor interrupt.
- **outbound-full** is raised by a processor write and lowered when the host consumes the byte.

Every host write also records the host address bit as a command/data marker. This lets the processor tell command bytes from data bytes.

The host side is asynchronous: an active-low chip select, one address bit, and active-low write and read strobes. These signals, together with the host write data, pass through a multi-flop synchronizer into the processor clock domain. Edges are detected only after synchronization. The processor side is a synchronous register bus with single-cycle read and write strobes and a two-bit address.

Top module: `host_mailbox`

## Requirements
- R1: A host write (chip select low, write strobe low then high) loads the host data byte into the inbound register. A processor read at slave address 0 then returns that byte.
- R2: A write-strobe pulse while host chip select is high has no effect. Inbound-full, the interrupt, the command/data bit and the inbound byte all stay as they were.
- R3: Each accepted host write sets inbound-full, and the processor interrupt output equals inbound-full.
- R4: A processor read at slave address 0 clears inbound-full. A processor read of the status register (slave address 2) leaves inbound-full unchanged.
- R5: On every accepted host write, the command/data bit takes the host address bit: 1 marks a command, 0 marks data.
- R6: A processor write at slave address 1 loads the outbound register and sets outbound-full. A host read with the address bit low returns the outbound byte.
- R7: A host read with the address bit low clears outbound-full. A host read with the address bit high returns the status byte and does not clear outbound-full.
- R8: The status byte has outbound-full in bit 0, inbound-full in bit 1 and command/data in bit 3, with every other bit 0. The same byte is seen at slave address 2 and on a host read with the address bit high.
- R9: If a flag's set event and clear event land in the same clock cycle, the flag ends up set.
- R10: After reset, both full flags, the command/data bit and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_a0 | input | 1 | Host address bit: command/data marker on writes, status select on reads |
| host_wr_n | input | 1 | Host write strobe, active low; its rising edge commits the write |
| host_rd_n | input | 1 | Host read strobe, active low; its rising edge completes the read |
| host_din | input | DATA_W | Host write data |
| host_dout | output | DATA_W | Host read data (outbound byte or status) |
| slv_addr | input | 2 | Slave address: 0 inbound, 1 outbound, 2 status |
| slv_wr | input | 1 | Slave write strobe, one cycle |
| slv_rd | input | 1 | Slave read strobe, one cycle |
| slv_wdata | input | DATA_W | Slave write data |
| slv_rdata | output | DATA_W | Slave read data |
| slv_irq | output | 1 | Interrupt request to the processor, high while inbound-full |

## Verification
The assertions assume that the host holds chip select, the address bit and the write data steady from before a strobe's falling edge until several clocks after its rising edge. Under that assumption, a synchronized strobe edge always sees the matching qualifiers and data. The bench meets this by driving every host signal on the falling clock edge and keeping strobes low for three cycles and qualifiers for five more after release. Slave strobes are assumed to be one cycle wide and applied between rising edges. The bench times the same-cycle set/clear cases by counting the two synchronizer edges plus the edge-detect cycle.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;

  // Slave-side register addresses
  typedef enum logic [1:0] {
    SA_INBOUND  = 2'd0,
    SA_OUTBOUND = 2'd1,
    SA_STATUS   = 2'd2,
    SA_UNUSED   = 2'd3
  } slv_addr_e;

  // Low nibble of the status byte; upper bits are zero-filled by the top.
  function automatic logic [3:0] status_nibble(input logic out_full,
                                               input logic in_full,
                                               input logic cmd);
    status_nibble = {cmd, 1'b0, in_full, out_full};
  endfunction

  // Rising edge of a synchronized level, given its previous value.
  function automatic logic rose(input logic now_v, input logic prev_v);
    rose = now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/hmbx_sync.sv
module hmbx_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= RST_VAL;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hmbx_flag.sv
module hmbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic q
);
  // Set takes priority over clear when both arrive in one cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (set_ev) q <= 1'b1;
    else if (clr_ev) q <= 1'b0;
  end
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_a0,
  input  logic              host_wr_n,
  input  logic              host_rd_n,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  input  logic [1:0]        slv_addr,
  input  logic              slv_wr,
  input  logic              slv_rd,
  input  logic [DATA_W-1:0] slv_wdata,
  output logic [DATA_W-1:0] slv_rdata,
  output logic              slv_irq
);
  import hmbx_pkg::*;

  localparam int CTL_W = 4;
  localparam int PAD_W = DATA_W - 4;
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1011; // cs_n, a0, wr_n, rd_n

  // Synchronized host controls and data
  logic [CTL_W-1:0]  ctl_s;
  logic [DATA_W-1:0] din_s;
  logic cs_n_s, a0_s, wr_n_s, rd_n_s;
  logic wr_n_q, rd_n_q;

  hmbx_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_cs_n, host_a0, host_wr_n, host_rd_n}),
    .q(ctl_s)
  );

  hmbx_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(host_din), .q(din_s)
  );

  assign {cs_n_s, a0_s, wr_n_s, rd_n_s} = ctl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
      rd_n_q <= 1'b1;
    end else begin
      wr_n_q <= wr_n_s;
      rd_n_q <= rd_n_s;
    end
  end

  // Named internal events (also watched by the checker)
  logic host_wr_evt, host_out_rd_evt, slv_in_rd, slv_out_wr;

  assign host_wr_evt     = rose(wr_n_s, wr_n_q) & ~cs_n_s;
  assign host_out_rd_evt = rose(rd_n_s, rd_n_q) & ~cs_n_s & ~a0_s;
  assign slv_in_rd       = slv_rd & (slv_addr == SA_INBOUND);
  assign slv_out_wr      = slv_wr & (slv_addr == SA_OUTBOUND);

  // Flags
  logic in_full, out_full, cmd_q;

  hmbx_flag u_in_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(host_wr_evt), .clr_ev(slv_in_rd), .q(in_full)
  );

  hmbx_flag u_out_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(slv_out_wr), .clr_ev(host_out_rd_evt), .q(out_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cmd_q <= 1'b0;
    else if (host_wr_evt) cmd_q <= a0_s;
  end

  // Data registers: no reset, contents undefined until first write
  logic [DATA_W-1:0] in_reg, out_reg;

  always_ff @(posedge clk) begin
    if (host_wr_evt) in_reg <= din_s;
  end

  always_ff @(posedge clk) begin
    if (slv_out_wr) out_reg <= slv_wdata;
  end

  // Read paths
  logic [DATA_W-1:0] status_word;
  assign status_word = {{PAD_W{1'b0}}, status_nibble(out_full, in_full, cmd_q)};

  assign host_dout = host_cs_n ? '0 : (host_a0 ? status_word : out_reg);

  always_comb begin
    unique case (slv_addr)
      SA_INBOUND:  slv_rdata = in_reg;
      SA_OUTBOUND: slv_rdata = out_reg;
      SA_STATUS:   slv_rdata = status_word;
      default:     slv_rdata = '0;
    endcase
  end

  assign slv_irq = in_full;

endmodule

// File: rtl/host_mailbox_chk.sv
module host_mailbox_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_evt,
  input logic              host_out_rd_evt,
  input logic              slv_in_rd,
  input logic              slv_out_wr,
  input logic              a0_s,
  input logic              in_full,
  input logic              out_full,
  input logic              cmd_q,
  input logic [1:0]        slv_addr,
  input logic [DATA_W-1:0] slv_rdata
);
  AST_IN_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_evt |=> in_full); // R3
  AST_IN_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    slv_in_rd && !host_wr_evt |=> !in_full); // R4
  AST_IN_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_in_rd && !host_wr_evt |=> $stable(in_full)); // R4
  AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_evt |=> cmd_q == $past(a0_s)); // R5
  AST_OUT_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    slv_out_wr |=> out_full); // R6
  AST_OUT_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    host_out_rd_evt && !slv_out_wr |=> !out_full); // R7
  AST_OUT_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_out_rd_evt && !slv_out_wr |=> $stable(out_full)); // R7
  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    slv_addr == 2'd2 |-> ((slv_rdata >> 4) == '0 && !slv_rdata[2])); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_evt && slv_in_rd) || (slv_out_wr && host_out_rd_evt)
      |=> in_full || out_full); // R9
endmodule

bind host_mailbox host_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_wr_evt(host_wr_evt), .host_out_rd_evt(host_out_rd_evt),
  .slv_in_rd(slv_in_rd), .slv_out_wr(slv_out_wr), .a0_s(a0_s),
  .in_full(in_full), .out_full(out_full), .cmd_q(cmd_q),
  .slv_addr(slv_addr), .slv_rdata(slv_rdata)
);

// File: tb/host_mailbox_test.sv
module host_mailbox_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_cs_n = 1'b1, host_a0 = 1'b0, host_wr_n = 1'b1, host_rd_n = 1'b1;
  logic [7:0] host_din = '0, slv_wdata = '0;
  logic [1:0] slv_addr = 2'd3;
  logic slv_wr = 1'b0, slv_rd = 1'b0;
  logic [7:0] host_dout, slv_rdata;
  logic slv_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  host_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .host_cs_n(host_cs_n), .host_a0(host_a0), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
    .host_din(host_din), .host_dout(host_dout),
    .slv_addr(slv_addr), .slv_wr(slv_wr), .slv_rd(slv_rd),
    .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .slv_irq(slv_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input int obf, input int ibf, input int cmd);
    return 8'(obf + 2 * ibf + 8 * cmd);
  endfunction

  task automatic host_write(input logic cs_n, input logic a0, input logic [7:0] d);
    @(negedge clk);
    host_cs_n = cs_n; host_a0 = a0; host_din = d; host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (5) @(negedge clk);
    host_cs_n = 1'b1;
  endtask

  task automatic host_read(input logic a0, output logic [7:0] d);
    @(negedge clk);
    host_cs_n = 1'b0; host_a0 = a0; host_rd_n = 1'b0;
    #1 d = host_dout;
    repeat (3) @(negedge clk);
    host_rd_n = 1'b1;
    repeat (5) @(negedge clk);
    host_cs_n = 1'b1;
  endtask

  task automatic slave_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    slv_addr = a; slv_rd = 1'b1;
    #1 d = slv_rdata;
    @(negedge clk);
    slv_rd = 1'b0; slv_addr = 2'd3;
  endtask

  task automatic slave_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    slv_addr = a; slv_wdata = d; slv_wr = 1'b1;
    @(negedge clk);
    slv_wr = 1'b0; slv_addr = 2'd3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int cmd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 irq", {7'b0, slv_irq}, 8'h00);
    slave_read(2'd2, rd); check("R10 slave status", rd, 8'h00);
    host_read(1'b1, rd);  check("R10 host status", rd, 8'h00);

    // Sweep all bytes host -> slave
    cmd = 0;
    for (int v = 0; v < 256; v++) begin
      host_write(1'b0, v[0], 8'(v));
      cmd = v % 2;
      check("R3 irq set", {7'b0, slv_irq}, 8'h01);
      slave_read(2'd2, rd); check("R5/R8 status after write", rd, exp_status(0, 1, cmd));
      slave_read(2'd0, rd); check("R1 inbound byte", rd, 8'(v));
      check("R4 irq cleared", {7'b0, slv_irq}, 8'h00);
      slave_read(2'd2, rd); check("R4 status after read", rd, exp_status(0, 0, cmd));
    end

    // Sweep all bytes slave -> host
    for (int v = 0; v < 256; v++) begin
      slave_write(2'd1, 8'(v));
      host_read(1'b1, rd); check("R8 host status", rd, exp_status(1, 0, cmd));
      host_read(1'b1, rd); check("R7 status read keeps flag", rd, exp_status(1, 0, cmd));
      host_read(1'b0, rd); check("R6 outbound byte", rd, 8'(v));
      slave_read(2'd2, rd); check("R7 flag cleared", rd, exp_status(0, 0, cmd));
    end

    // R2: write with chip select high is ignored
    host_write(1'b1, 1'b0, 8'hA5);
    check("R2 irq", {7'b0, slv_irq}, 8'h00);
    slave_read(2'd2, rd); check("R2 status", rd, exp_status(0, 0, cmd));
    slave_read(2'd0, rd); check("R2 inbound unchanged", rd, 8'hFF);

    // R4: status read leaves inbound-full
    host_write(1'b0, 1'b0, 8'h3C); cmd = 0;
    slave_read(2'd2, rd); slave_read(2'd2, rd);
    check("R4 status read keeps flag", rd, exp_status(0, 1, 0));
    check("R3 irq follows flag", {7'b0, slv_irq}, 8'h01);

    // R9: host write edge detected in same cycle as slave inbound read
    @(negedge clk);
    host_cs_n = 1'b0; host_a0 = 1'b1; host_din = 8'h5A; host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); slv_addr = 2'd0; slv_rd = 1'b1;
    @(negedge clk); slv_rd = 1'b0; slv_addr = 2'd3;
    repeat (4) @(negedge clk); host_cs_n = 1'b1;
    slave_read(2'd2, rd); check("R9 inbound set wins", rd, exp_status(0, 1, 1));
    slave_read(2'd0, rd); check("R9 inbound new byte", rd, 8'h5A);

    // R9: slave outbound write in same cycle as host outbound read edge
    slave_write(2'd1, 8'h11);
    @(negedge clk);
    host_cs_n = 1'b0; host_a0 = 1'b0; host_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    host_rd_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); slv_addr = 2'd1; slv_wdata = 8'h22; slv_wr = 1'b1;
    @(negedge clk); slv_wr = 1'b0; slv_addr = 2'd3;
    repeat (4) @(negedge clk); host_cs_n = 1'b1;
    slave_read(2'd2, rd); check("R9 outbound set wins", rd, exp_status(1, 0, 1));
    host_read(1'b0, rd); check("R9 outbound new byte", rd, 8'h22);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule